// File: doc/BRIEF.md
# Dual-Mode Per-Processor Timer

This block is the timer that belongs to one processor. It runs in one of two modes, and a mode bit driven from a central mode register picks the mode. In counter mode the timer counts 500 ns ticks up to a programmable limit. When the count reaches the limit, the count returns to zero, a reached flag is set and an interrupt is raised. In user mode the same four-word register window becomes a 54-tick-bit free counter, split into a high word and a low word. Software starts and stops this counter, and it never raises an interrupt.

The central register drives a one-cycle `modeWr` strobe together with the new value of this processor's mode bit. The block acts on the strobe only when that value differs from its current mode, and the change shows in the cycle after the strobe. Register accesses are single-cycle strobes. `rdData` is combinational from `addr`, and any side effect of a read happens at the clock edge that ends the read cycle. A tick is a one-cycle enable that marks each 500 ns period. Each tick adds one at bit 9 of the count, and bits 8..0 always read as zero.

Top module: `dual_mode_timer`

## Requirements
- R1: After reset the timer is in counter mode, offset 3 reads 1 (running), the limit and the count are zero, the reached flag is clear and `irq` is low.
- R2: In counter mode, writing offset 0 loads the limit from bits 30..9, clears the count and lowers `irq`. Each tick adds 0x200 to the offset-1 read value. When the count would become equal to a nonzero limit, it returns to zero instead, bit 31 of offset 1 (reached) is set and `irq` rises.
- R3: In counter mode, reading offset 0 returns the limit in bits 30..9 and clears both reached and `irq`. Writing offset 2 loads the limit and keeps the count. Offset 2 always reads 0.
- R4: With a limit of zero in counter mode, neither `irq` nor reached is ever set, and the count wraps to zero when it would become 0x7FFFFE00.
- R5: A `modeWr` strobe with `modeBit`=1 while in counter mode enters user mode in the next cycle. It lowers `irq`, clears running, the count and reached. A strobe that carries the current mode changes nothing.
- R6: A `modeWr` strobe with `modeBit`=0 while in user mode returns to counter mode. Running is set, the count and reached are cleared, and the limit set earlier is kept.
- R7: In user mode, offset 0 reads {reached, count bits 62..32} and offset 1 reads count bits 31..9 in bits 31..9, with bits 8..0 zero.
- R8: In user mode, writing offset 0 loads count bits 62..32 from data bits 30..0, and writing offset 1 loads count bits 31..9 from data bits 31..9. Either write clears reached. A write to offset 1 in counter mode changes nothing.
- R9: In user mode, writing offset 3 with bit 0 = 1 starts the count and with bit 0 = 0 stops it. Offset 3 reads running in bit 0. In counter mode, offset-3 writes are ignored and the timer keeps running.
- R10: In user mode, a tick carries from the low word into the high word in the same cycle. When the count would become 0x7FFFFFFFFFFFFE00, it wraps to zero and sets reached. `irq` stays low for the whole time the timer is in user mode.
- R11: In user mode, reading offset 1 captures the high word as it stood in that cycle. The next offset-0 read returns the captured word and then releases it. A write to offset 0 or 1, or a mode change, also releases it.
- R12: A tick that falls in the same cycle as a register write that loads the count or resets it is lost, and the written value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle enable per 500 ns period |
| modeWr | input | 1 | Strobe from the central mode register write |
| modeBit | input | 1 | This processor's bit of the central mode register |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (side effects only) |
| addr | input | 2 | Word offset in the register window |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr` |
| irq | output | 1 | Limit-match interrupt, counter mode only |

## Verification
The hardest situations to reach are the wrap points of the wide user counter and a tick that lands in the same cycle as a high/low read pair. The bench gets to the wrap by loading the counter through offsets 0 and 1 to a few ticks below the carry or wrap point, and then letting single ticks through. It reaches the read race by raising a tick in the same cycle as the low-word read. It then checks that the following high-word read still returns the word from before the carry. A behavioural model runs beside the design and is compared on every clock.

// File: rtl/dual_mode_timer_pkg.sv
package dual_mode_timer_pkg;
  localparam int WORD_W = 32;

  typedef struct packed {
    logic loadHi;
    logic loadLo;
    logic setLimRst;
    logic setLimKeep;
    logic rdLimit;
    logic takeSnap;
    logic useSnap;
    logic toUser;
    logic toCounter;
    logic countEn;
  } tmr_strobe_t;
endpackage

// File: rtl/dmt_ctrl.sv
module dmt_ctrl
  import dual_mode_timer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        modeWr,
  input  logic        modeBit,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [1:0]  addr,
  input  logic        wrBit0,
  output logic        userMode,
  output logic        running,
  output tmr_strobe_t str
);
  logic modeChg, live, w0, w1, w2, w3, r0, r1;

  assign modeChg = modeWr && (modeBit != userMode);
  assign live    = !modeChg;
  assign w0 = wrEn && live && (addr == 2'd0);
  assign w1 = wrEn && live && (addr == 2'd1);
  assign w2 = wrEn && live && (addr == 2'd2);
  assign w3 = wrEn && live && (addr == 2'd3);
  assign r0 = rdEn && live && (addr == 2'd0);
  assign r1 = rdEn && live && (addr == 2'd1);

  always_comb begin
    str            = '0;
    str.loadHi     = w0 && userMode;
    str.loadLo     = w1 && userMode;
    str.setLimRst  = w0 && !userMode;
    str.setLimKeep = w2 && !userMode;
    str.rdLimit    = r0 && !userMode;
    str.takeSnap   = r1 && userMode;
    str.useSnap    = r0 && userMode;
    str.toUser     = modeChg && modeBit;
    str.toCounter  = modeChg && !modeBit;
    str.countEn    = tick && running && live;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      userMode <= 1'b0;
      running  <= 1'b1;
    end else if (str.toUser) begin
      userMode <= 1'b1;
      running  <= 1'b0;
    end else if (str.toCounter) begin
      userMode <= 1'b0;
      running  <= 1'b1;
    end else if (w3 && userMode) begin
      running  <= wrBit0;
    end
  end

  // R5: entering user mode stops the count
  p_enter_user_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeWr && modeBit && !userMode) |=> (userMode && !running));
  // R6: leaving user mode starts the count
  p_enter_counter_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeWr && !modeBit && userMode) |=> (!userMode && running));
  // R9: counter mode never stops
  p_counter_runs_r9: assert property (@(posedge clk) disable iff (!rstN)
    !userMode |-> running);
endmodule

// File: rtl/dmt_datapath.sv
module dmt_datapath
  import dual_mode_timer_pkg::*;
#(
  parameter int FINE_BITS = 9
) (
  input  logic               clk,
  input  logic               rstN,
  input  tmr_strobe_t        str,
  input  logic               userMode,
  input  logic               running,
  input  logic [1:0]         addr,
  input  logic [WORD_W-1:0]  wrData,
  output logic [WORD_W-1:0]  rdData,
  output logic               irq
);
  localparam int HI_W  = WORD_W - 1;
  localparam int LO_TW = WORD_W - FINE_BITS;
  localparam int LIM_W = WORD_W - 1 - FINE_BITS;
  localparam int CNT_W = LO_TW + HI_W;

  logic [CNT_W-1:0] cnt, nxtAll;
  logic [LIM_W-1:0] lim, nxtLo;
  logic [HI_W-1:0]  hiSnap;
  logic             reached, snapV;

  assign nxtAll = cnt + CNT_W'(1);
  assign nxtLo  = cnt[LIM_W-1:0] + LIM_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      lim     <= '0;
      hiSnap  <= '0;
      reached <= 1'b0;
      snapV   <= 1'b0;
      irq     <= 1'b0;
    end else if (str.toUser || str.toCounter) begin
      cnt     <= '0;
      reached <= 1'b0;
      snapV   <= 1'b0;
      if (str.toUser) irq <= 1'b0;
    end else begin
      if (str.setLimKeep) lim <= wrData[WORD_W-2:FINE_BITS];
      if (str.rdLimit) begin
        reached <= 1'b0;
        irq     <= 1'b0;
      end
      if (str.takeSnap) begin
        hiSnap <= cnt[CNT_W-1:LO_TW];
        snapV  <= 1'b1;
      end
      if (str.useSnap) snapV <= 1'b0;
      if (str.loadHi) begin
        cnt[CNT_W-1:LO_TW] <= wrData[HI_W-1:0];
        reached <= 1'b0;
        snapV   <= 1'b0;
      end else if (str.loadLo) begin
        cnt[LO_TW-1:0] <= wrData[WORD_W-1:FINE_BITS];
        reached <= 1'b0;
        snapV   <= 1'b0;
      end else if (str.setLimRst) begin
        lim <= wrData[WORD_W-2:FINE_BITS];
        cnt <= '0;
        irq <= 1'b0;
      end else if (str.countEn) begin
        if (userMode) begin
          if (&nxtAll) begin
            cnt     <= '0;
            reached <= 1'b1;
          end else begin
            cnt <= nxtAll;
          end
        end else if ((lim != '0) && (nxtLo == lim)) begin
          cnt     <= '0;
          reached <= 1'b1;
          irq     <= 1'b1;
        end else if ((lim == '0) && (&nxtLo)) begin
          cnt <= '0;
        end else begin
          cnt <= {{(CNT_W-LIM_W){1'b0}}, nxtLo};
        end
      end
    end
  end

  always_comb begin
    unique case (addr)
      2'd0: rdData = userMode ? {reached, (snapV ? hiSnap : cnt[CNT_W-1:LO_TW])}
                              : {1'b0, lim, {FINE_BITS{1'b0}}};
      2'd1: rdData = userMode ? {cnt[LO_TW-1:0], {FINE_BITS{1'b0}}}
                              : {reached, cnt[LIM_W-1:0], {FINE_BITS{1'b0}}};
      2'd2: rdData = '0;
      default: rdData = {{(WORD_W-1){1'b0}}, running};
    endcase
  end

  // R10: no interrupt while in user mode
  p_user_no_irq_r10: assert property (@(posedge clk) disable iff (!rstN)
    userMode |-> !irq);
  // R4: an interrupt needs a nonzero limit
  p_irq_needs_limit_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> ($past(lim) != '0));
  // R8: low word load takes the written bits
  p_load_lo_r8: assert property (@(posedge clk) disable iff (!rstN)
    str.loadLo |=> (cnt[LO_TW-1:0] == $past(wrData[WORD_W-1:FINE_BITS])));
  // R12: a resetting limit write beats a tick
  p_write_wins_r12: assert property (@(posedge clk) disable iff (!rstN)
    str.setLimRst |=> (cnt == '0));
endmodule

// File: rtl/dual_mode_timer.sv
module dual_mode_timer
  import dual_mode_timer_pkg::*;
#(
  parameter int FINE_BITS = 9
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic        modeWr,
  input  logic        modeBit,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [1:0]  addr,
  input  logic [31:0] wrData,
  output logic [31:0] rdData,
  output logic        irq
);
  tmr_strobe_t str;
  logic        userMode, running;

  dmt_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .modeWr(modeWr), .modeBit(modeBit),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrBit0(wrData[0]),
    .userMode(userMode), .running(running), .str(str)
  );

  dmt_datapath #(.FINE_BITS(FINE_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .str(str), .userMode(userMode), .running(running),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irq(irq)
  );
endmodule

// File: tb/tb_dual_mode_timer.sv
module tb_dual_mode_timer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tick = 1'b0, modeWr = 1'b0, modeBit = 1'b0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        irq;

  int compared = 0, mismatched = 0;
  string phase = "R1";
  logic [31:0] sampled;

  dual_mode_timer dut (
    .clk(clk), .rstN(rstN), .tick(tick), .modeWr(modeWr), .modeBit(modeBit),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .irq(irq)
  );

  always #10 clk = ~clk;

  // behavioural reference
  logic        mUser, mRun, mReached, mIrq, mSnapV, wrote;
  logic [53:0] mCnt, c0;
  logic [21:0] mLim, l0, n22;
  logic [30:0] mSnap;
  logic        r0;

  always @(posedge clk) begin
    if (!rstN) begin
      mUser = 0; mRun = 1; mReached = 0; mIrq = 0; mSnapV = 0;
      mCnt = '0; mLim = '0; mSnap = '0;
    end else if (modeWr && (modeBit != mUser)) begin
      mUser = modeBit; mRun = !modeBit; mCnt = '0; mReached = 0; mSnapV = 0;
      if (modeBit) mIrq = 0;
    end else begin
      c0 = mCnt; l0 = mLim; r0 = mRun; wrote = 0;
      if (wrEn) begin
        case (addr)
          2'd0: if (mUser) begin mCnt[53:23] = wrData[30:0]; mReached = 0; mSnapV = 0; wrote = 1; end
                else begin mLim = wrData[30:9]; mCnt = '0; mIrq = 0; wrote = 1; end
          2'd1: if (mUser) begin mCnt[22:0] = wrData[31:9]; mReached = 0; mSnapV = 0; wrote = 1; end
          2'd2: if (!mUser) mLim = wrData[30:9];
          default: if (mUser) mRun = wrData[0];
        endcase
      end
      if (rdEn) begin
        if (addr == 2'd0) begin
          if (mUser) mSnapV = 0; else begin mReached = 0; mIrq = 0; end
        end
        if (addr == 2'd1 && mUser) begin mSnap = c0[53:23]; mSnapV = 1; end
      end
      if (!wrote && tick && r0) begin
        if (mUser) begin
          if (c0 + 54'd1 == {54{1'b1}}) begin mCnt = '0; mReached = 1; end
          else mCnt = c0 + 54'd1;
        end else begin
          n22 = c0[21:0] + 22'd1;
          if (l0 != 0 && n22 == l0) begin mCnt = '0; mReached = 1; mIrq = 1; end
          else if (l0 == 0 && n22 == {22{1'b1}}) mCnt = '0;
          else mCnt = {32'd0, n22};
        end
      end
    end
  end

  function automatic logic [31:0] expRead(input logic [1:0] a);
    case (a)
      2'd0: return mUser ? {mReached, (mSnapV ? mSnap : mCnt[53:23])} : {1'b0, mLim, 9'd0};
      2'd1: return mUser ? {mCnt[22:0], 9'd0} : {mReached, mCnt[21:0], 9'd0};
      2'd2: return 32'd0;
      default: return {31'd0, mRun};
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
    if (rstN) begin
      chk({phase, " irq"}, {31'd0, irq}, {31'd0, mIrq});
      chk({phase, " rdData"}, rdData, expRead(addr));
    end
  endtask

  task automatic pk(input string tag, input logic [1:0] a, input logic [31:0] exp);
    addr = a; cyc(); chk(tag, rdData, exp);
  endtask

  task automatic wrT(input logic [1:0] a, input logic [31:0] d, input logic t);
    addr = a; wrData = d; wrEn = 1; tick = t; cyc(); wrEn = 0; tick = 0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wrT(a, d, 1'b0);
  endtask

  task automatic rdT(input logic [1:0] a, input logic t);
    addr = a; rdEn = 1; tick = t; #5 sampled = rdData; cyc(); rdEn = 0; tick = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin tick = 1; cyc(); end
    tick = 0;
  endtask

  task automatic mode(input logic b);
    modeBit = b; modeWr = 1; cyc(); modeWr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    phase = "R1";
    pk("R1 status", 2'd3, 32'd1);
    pk("R1 count", 2'd1, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    phase = "R2";
    wr(2'd0, 32'h0000_0A00);
    idle(4);
    pk("R2 count", 2'd1, 32'h0000_0800);
    idle(1);
    pk("R2 reached", 2'd1, 32'h8000_0000);
    chk("R2 irq", {31'd0, irq}, 32'd1);

    phase = "R3";
    rdT(2'd0, 1'b0);
    chk("R3 limit read", sampled, 32'h0000_0A00);
    chk("R3 irq cleared", {31'd0, irq}, 32'd0);
    pk("R3 reached cleared", 2'd1, 32'd0);
    idle(3);
    wr(2'd2, 32'h0000_1000);
    pk("R3 count kept", 2'd1, 32'h0000_0600);
    pk("R3 offset2", 2'd2, 32'd0);
    idle(5);
    pk("R3 new limit match", 2'd1, 32'h8000_0000);

    phase = "R4";
    rdT(2'd0, 1'b0);
    wr(2'd0, 32'd0);
    idle(20);
    chk("R4 no irq", {31'd0, irq}, 32'd0);
    pk("R4 free count", 2'd1, 32'h0000_2800);

    phase = "R5";
    mode(1'b0);
    pk("R5 same mode status", 2'd3, 32'd1);
    pk("R5 same mode count", 2'd1, 32'h0000_2800);
    wr(2'd0, 32'h0000_0200);
    idle(1);
    chk("R5 irq before", {31'd0, irq}, 32'd1);
    mode(1'b1);
    chk("R5 irq lowered", {31'd0, irq}, 32'd0);
    pk("R5 stopped", 2'd3, 32'd0);
    pk("R5 count cleared", 2'd1, 32'd0);
    pk("R5 high cleared", 2'd0, 32'd0);

    phase = "R9";
    wr(2'd3, 32'd1);
    pk("R9 started", 2'd3, 32'd1);
    mode(1'b1);
    pk("R5 repeat no effect", 2'd3, 32'd1);
    idle(3);
    pk("R9 counting", 2'd1, 32'h0000_0600);
    wr(2'd3, 32'd0);
    idle(5);
    pk("R9 stopped hold", 2'd1, 32'h0000_0600);
    wr(2'd3, 32'd1);

    phase = "R8";
    wr(2'd0, 32'hFFFF_FFFF);
    pk("R7 high read", 2'd0, 32'h7FFF_FFFF);
    wr(2'd1, 32'hFFFF_F9FF);
    pk("R7 low read", 2'd1, 32'hFFFF_F800);

    phase = "R10";
    idle(1);
    pk("R10 tick", 2'd1, 32'hFFFF_FA00);
    idle(2);
    pk("R10 wrap reached", 2'd0, 32'h8000_0000);
    pk("R10 wrap low", 2'd1, 32'd0);
    chk("R10 no irq", {31'd0, irq}, 32'd0);
    wr(2'd0, 32'd5);
    pk("R8 reached cleared", 2'd0, 32'd5);
    wr(2'd1, 32'hFFFF_FE00);
    idle(1);
    pk("R10 carry high", 2'd0, 32'd6);
    pk("R10 carry low", 2'd1, 32'd0);

    phase = "R11";
    wr(2'd1, 32'hFFFF_FE00);
    rdT(2'd1, 1'b1);
    chk("R11 low read", sampled, 32'hFFFF_FE00);
    rdT(2'd0, 1'b0);
    chk("R11 held high", sampled, 32'd6);
    pk("R11 released", 2'd0, 32'd7);
    rdT(2'd1, 1'b0);
    wr(2'd0, 32'd9);
    pk("R11 write releases", 2'd0, 32'd9);

    phase = "R6";
    mode(1'b0);
    pk("R6 limit kept", 2'd0, 32'h0000_0200);
    pk("R6 running", 2'd3, 32'd1);
    pk("R6 count cleared", 2'd1, 32'd0);
    wr(2'd3, 32'd0);
    pk("R9 counter ignores stop", 2'd3, 32'd1);
    wr(2'd1, 32'h1234_5600);
    pk("R8 counter ignores low write", 2'd1, 32'd0);
    idle(1);
    chk("R6 irq after match", {31'd0, irq}, 32'd1);

    phase = "R12";
    wrT(2'd0, 32'h0000_0400, 1'b1);
    pk("R12 write beats tick", 2'd1, 32'h8000_0000);
    chk("R12 irq lowered", {31'd0, irq}, 32'd0);
    idle(1);
    pk("R12 counts after", 2'd1, 32'h8000_0200);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule